// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns a 32-bit address issued by a DMA master on a PCI bus into a 34-bit system memory address. Four windows are programmed from outside. Each window has a 64-bit base word, a 64-bit mask word and a 64-bit translated-base word, and the block reads all three as plain inputs. The base word enables a window with bit 0 and selects its mode with bit 1.

A window that matches the bus address translates it in one of two modes. In direct mode the block splices the low bus-address bits onto the translated base. In scatter-gather mode the block fetches one 64-bit page-table entry from memory and builds the final address from that entry. An address that matches no enabled window passes through unchanged.

Translations use a valid/ready request channel and a valid/ready response channel. Page-table reads go out on a valid/ready read-request port and come back on a valid-only data port. Only one translation is in flight at a time.

Top module: `pci_dma_xlate`

## Requirements
- R1: A window matches when the bus address agrees with its base word on every bit position p in 31:20 for which bit p of the mask word is 0. Bits 19:0 are never compared.
- R2: A window whose base word has bit 0 clear never translates, even when it matches. Checking then continues with the next window.
- R3: Windows are checked from index 0 upward. The lowest-index window that both matches and is enabled is used.
- R4: Direct mode applies when bit 1 of the base word is 0. Let P be mask bits 31:20 together with all of bits 19:0. The result takes the P positions from the bus address and every other position from the translated-base word.
- R5: Scatter-gather mode applies when bit 1 of the base word is 1. The block issues exactly one page-entry read at address (T & ~((F>>10)|0x3FF)) | ((A & (F|0xFE000))>>10). Here T is the translated-base word, F is the mask word restricted to bits 31:20 and A is the bus address. While the read is not accepted, the read request and its address stay asserted and unchanged.
- R6: The scatter-gather result is ((E & ~1) << 12) | A[12:0], where E is the returned 64-bit entry.
- R7: Every translated result is cut to its low 34 bits. Translated-base bits above 33 never reach the output.
- R8: When no enabled window matches, the result is the bus address, zero-extended.
- R9: After a request is accepted, request-ready stays low until the response has been accepted. It is high again in the cycle after the response handshake.
- R10: A direct or pass-through result is valid one cycle after the request is accepted. A scatter-gather result is valid in the cycle after the returned entry is valid.
- R11: A valid response that is not accepted stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Translated address valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_addr | output | 34 | Translated system address |
| win_base | input | NUM_WIN x 64 | Per-window base word (bit 0 enable, bit 1 scatter-gather) |
| win_mask | input | NUM_WIN x 64 | Per-window mask word (bits 31:20 used) |
| win_tbase | input | NUM_WIN x 64 | Per-window translated-base word |
| mem_rd_valid | output | 1 | Page-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 64 | Page-entry address |
| mem_rsp_valid | input | 1 | Returned entry valid |
| mem_rsp_data | input | 64 | Returned page-table entry |

## Verification
Most internal faults change the translated address. A wrong window choice, a wrong mask slice or a stale low-bit register each shows up in the very next response on rsp_addr. For scatter-gather windows, a wrong entry address is already visible on mem_rd_addr at least a cycle before the response. A sequencing fault shows at the ports instead of in the address. Examples are re-opening request-ready too early, dropping a held response, or missing the returned entry. These appear as request-ready rising while a response or fetch is pending, as a response one cycle late, or as a response that never comes, and they are caught on the cycle they occur.

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate #(
  parameter int NUM_WIN = 4,
  parameter int SYS_W   = 34
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [31:0]              req_addr,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [SYS_W-1:0]         rsp_addr,
  input  logic [NUM_WIN-1:0][63:0] win_base,
  input  logic [NUM_WIN-1:0][63:0] win_mask,
  input  logic [NUM_WIN-1:0][63:0] win_tbase,
  output logic                     mem_rd_valid,
  input  logic                     mem_rd_ready,
  output logic [63:0]              mem_rd_addr,
  input  logic                     mem_rsp_valid,
  input  logic [63:0]              mem_rsp_data
);
  localparam int PG_LO = 13;
  localparam logic [63:0] LOW_PASS = 64'h0000_0000_000F_FFFF;
  localparam logic [63:0] IDX_BITS = 64'h0000_0000_000F_E000;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} state_t;
  state_t st;

  logic        sel_hit, sel_sg;
  logic [11:0] sel_mask;
  logic [63:0] sel_tba;

  always_comb begin
    sel_hit  = 1'b0;
    sel_sg   = 1'b0;
    sel_mask = '0;
    sel_tba  = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!sel_hit && win_base[i][0] &&
          (((req_addr[31:20] ^ win_base[i][31:20]) & ~win_mask[i][31:20]) == 12'h0)) begin
        sel_hit  = 1'b1;
        sel_sg   = win_base[i][1];
        sel_mask = win_mask[i][31:20];
        sel_tba  = win_tbase[i];
      end
    end
  end

  logic [63:0] bus64, fmask, pass, direct_res, entry_addr;
  assign bus64      = {32'h0, req_addr};
  assign fmask      = {32'h0, sel_mask, 20'h0};
  assign pass       = fmask | LOW_PASS;
  assign direct_res = (sel_tba & ~pass) | (bus64 & pass);
  assign entry_addr = (sel_tba & ~((fmask >> 10) | 64'h3FF)) |
                      ((bus64 & (fmask | IDX_BITS)) >> 10);

  logic [SYS_W-1:0] res_q;
  logic [PG_LO-1:0] low_q;
  logic [63:0]      rd_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      res_q     <= '0;
      low_q     <= '0;
      rd_addr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          low_q <= req_addr[PG_LO-1:0];
          if (sel_hit && sel_sg) begin
            rd_addr_q <= entry_addr;
            st        <= S_FETCH;
          end else begin
            res_q <= sel_hit ? direct_res[SYS_W-1:0] : SYS_W'(req_addr);
            st    <= S_DONE;
          end
        end
        S_FETCH: if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          res_q <= {mem_rsp_data[SYS_W-PG_LO:1], low_q};
          st    <= S_DONE;
        end
        default: if (rsp_ready) st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE);
  assign rsp_valid    = (st == S_DONE);
  assign rsp_addr     = res_q;
  assign mem_rd_valid = (st == S_FETCH);
  assign mem_rd_addr  = rd_addr_q;

  logic unused_bits;
  assign unused_bits = ^{win_base, win_mask, mem_rsp_data, direct_res};
endmodule

// File: rtl/pci_dma_xlate_checker.sv
module pci_dma_xlate_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [33:0] rsp_addr,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [63:0] mem_rd_addr,
  input logic        mem_rsp_valid
);
  logic waiting;
  always_ff @(posedge clk) begin
    if (!rst_n) waiting <= 1'b0;
    else if (mem_rd_valid && mem_rd_ready) waiting <= 1'b1;
    else if (mem_rsp_valid) waiting <= 1'b0;
  end

  assert_busy_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_busy_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || waiting) |-> !req_ready);
  assert_accept_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_rd_valid));
  assert_sg_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && mem_rsp_valid) |=> rsp_valid);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)));
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && mem_rd_valid));
endmodule

bind pci_dma_xlate pci_dma_xlate_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pci_dma_xlate_bench.sv
`timescale 1ns/1ps
module pci_dma_xlate_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic             req_valid = 0, rsp_ready = 0;
  logic [31:0]      req_addr = 0;
  logic             req_ready, rsp_valid, mem_rd_valid;
  logic [33:0]      rsp_addr;
  logic [63:0]      mem_rd_addr;
  logic             mem_rd_ready, mem_rsp_valid;
  logic [63:0]      mem_rsp_data;
  logic [3:0][63:0] wb = '0, wm = '0, wt = '0;

  pci_dma_xlate u_pci_dma_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .win_base(wb), .win_mask(wm), .win_tbase(wt),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  int checks = 0, fails = 0, rd_count = 0;
  logic [63:0] last_rd = 0;

  function automatic logic [63:0] pte_of(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'h0000_0000_5A5A_C3C3;
  endfunction

  initial begin
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        last_rd = mem_rd_addr; rd_count++;
        mem_rd_ready = 1; @(negedge clk); mem_rd_ready = 0;
        repeat ($urandom_range(0, 4)) @(negedge clk);
        mem_rsp_data = pte_of(last_rd); mem_rsp_valid = 1;
        @(negedge clk); mem_rsp_valid = 0; mem_rsp_data = 0;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [31:0] a);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] cmp = {~wm[i][31:20], 20'h0};
      if (wb[i][0] && ((a & cmp) == (wb[i][31:0] & cmp))) return i;
    end
    return -1;
  endfunction

  task automatic run(input logic [31:0] a, input int hold, input string tag);
    int w, n, rc0;
    logic prev, busy_bad, sg;
    logic [63:0] pm, fm, ent, exp64;
    logic [33:0] held;
    w = pick(a); rc0 = rd_count; sg = (w >= 0) && wb[w][1];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; rsp_ready = 0;
    @(posedge clk); #1 req_valid = 0;
    n = 0; prev = 0; busy_bad = 0;
    forever begin
      @(negedge clk); #1; n++;
      if (req_ready) busy_bad = 1;
      if (rsp_valid || n > 300) break;
      prev = mem_rsp_valid;
    end
    chk(rsp_valid, {tag, " response arrives"}, 64'(rsp_valid), 64'd1);
    chk(!busy_bad, "R9 ready low while busy", 64'(busy_bad), 64'd0);
    if (sg) chk(prev, "R10 sg result follows entry", 64'(prev), 64'd1);
    else chk(n == 1, "R10 one-cycle latency", 64'(n), 64'd1);
    if (w < 0) exp64 = {32'h0, a};
    else if (!sg) begin
      pm = {32'h0, wm[w][31:20], 20'hFFFFF};
      exp64 = (wt[w] & ~pm) | ({32'h0, a} & pm);
    end else begin
      fm = {32'h0, wm[w][31:20], 20'h0};
      ent = (wt[w] & ~((fm >> 10) | 64'h3FF)) | (({32'h0, a} & (fm | 64'hFE000)) >> 10);
      chk(last_rd == ent, "R5 entry address", last_rd, ent);
      chk(rd_count == rc0 + 1, "R5 single read", 64'(rd_count - rc0), 64'd1);
      exp64 = ((pte_of(ent) & ~64'h1) << 12) | {51'h0, a[12:0]};
    end
    if (!sg) chk(rd_count == rc0, "R5 no read outside sg", 64'(rd_count - rc0), 64'd0);
    chk(rsp_addr == exp64[33:0], tag, 64'(rsp_addr), 64'(exp64[33:0]));
    held = rsp_addr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid && rsp_addr == held, "R11 response held", 64'(rsp_addr), 64'(held));
    end
    rsp_ready = 1; @(posedge clk); #1 rsp_ready = 0;
    chk(req_ready && !rsp_valid, "R9 ready after accept", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready && !rsp_valid && !mem_rd_valid, "reset state", {61'h0, req_ready, rsp_valid, mem_rd_valid}, 64'h4);
  endtask

  task automatic t_miss;
    wb = '0; wm = '0; wt = '0;
    run(32'h1234_5678, 0, "R8 pass-through");
    wb[0] = 64'h4000_0000; wt[0] = 64'h3_0000_0000;
    run(32'h4001_2345, 0, "R2 disabled hit passes");
  endtask

  task automatic t_direct;
    wb[0] = 64'h4000_0001; wm[0] = 64'h0030_0000; wt[0] = 64'h3_1230_0000;
    run(32'h4012_3456, 0, "R4 direct map");
    run(32'h403F_FFFF, 1, "R1 window top edge");
    run(32'h5000_0010, 0, "R1 outside window");
    chk(rsp_addr == 34'h5000_0010, "R8 miss value", 64'(rsp_addr), 64'h5000_0010);
  endtask

  task automatic t_priority;
    wb[0] = 64'h0;
    wb[1] = 64'h6000_0001; wm[1] = 64'h0FF0_0000; wt[1] = 64'h1_0000_0000;
    wb[2] = 64'h6800_0001; wm[2] = 64'h0;         wt[2] = 64'h2_0000_0000;
    run(32'h6800_1234, 0, "R3 lowest index wins");
    chk(rsp_addr[33:28] == 6'h10, "R3 window one used", 64'(rsp_addr), 64'h1_0800_1234);
    wb[1] = 64'h6000_0000;
    run(32'h6800_1234, 0, "R2 disabled skipped");
    chk(rsp_addr[33:32] == 2'b10, "R2 window two used", 64'(rsp_addr), 64'h2_0000_1234);
  endtask

  task automatic t_trunc;
    wb = '0;
    wb[0] = 64'h4000_0001; wm[0] = 64'h0; wt[0] = 64'hFFFF_FFFF_0000_0000;
    run(32'h4000_0ABC, 0, "R7 truncated result");
    chk(rsp_addr == 34'h3_0000_0ABC, "R7 upper bits", 64'(rsp_addr), 64'h3_0000_0ABC);
  endtask

  task automatic t_sg;
    wb[3] = 64'h8000_0003; wm[3] = 64'h0010_0000; wt[3] = 64'h0000_0001_2345_6000;
    run(32'h801A_BCDE, 0, "R6 sg result");
    run(32'h8000_1FFF, 3, "R6 sg low bits");
    wm[3] = 64'h0;
    run(32'h800F_E123, 2, "R6 sg narrow mask");
  endtask

  task automatic t_mixed;
    wb[1] = 64'hC000_0003; wm[1] = 64'h0070_0000; wt[1] = 64'h0000_00AB_CDE0_0000;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a;
      case (k % 4)
        0: a = 32'h4000_0000 | $urandom_range(0, 32'hFFFFF);
        1: a = 32'h8000_0000 | $urandom_range(0, 32'hFFFFF);
        2: a = 32'hC000_0000 | $urandom_range(0, 32'h7FFFFF);
        default: a = $urandom;
      endcase
      run(a, $urandom_range(0, 2), "R4 R6 mixed sequence");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk) rst_n = 1;
    t_miss;
    t_direct;
    t_priority;
    t_trunc;
    t_sg;
    t_mixed;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule